// File: doc/BRIEF.md
# SMBus Packet Error Check Engine

This block runs beside the byte engine of an I2C controller and keeps the SMBus packet error code, an 8-bit CRC, over every byte that crosses the bus in either direction. It also decides where the code byte sits at the end of a transfer. A transmitter is told when to send the code byte. A receiver is told that the coming byte is the code, and the block checks that byte against its own remainder. Both decisions can be triggered by the end-of-transfer signals of a DMA channel or by a software request.

A final-transfer bit separates intermediate code transfers from the closing one. When a master receiver reaches its closing code byte, the block asks for a NACK on that byte. A mismatch on a received code sets a sticky error flag that can drive an interrupt line. An arbitration loss marks the running value as unusable until the next start condition.

The sequencer has five states:
- `ST_RUN`: accumulating.
- `ST_TX_ARM`: a DMA end-of-transfer has been seen while transmitting, and the block waits for the last data byte.
- `ST_TX_PEC`: the code byte is requested.
- `ST_RX_PEC`: the next received byte is the code.
- `ST_LOST`: the value is corrupted by arbitration loss.

The transitions are:
- `ST_RUN`→`ST_TX_ARM` on DMA end-of-transfer.
- `ST_RUN`→`ST_TX_PEC` on a software request while transmitting.
- `ST_TX_ARM`→`ST_TX_PEC` on the last data byte.
- `ST_TX_PEC`→`ST_RUN` on the code byte.
- `ST_RUN`→`ST_RX_PEC` on an early end-of-transfer or a software request while receiving.
- `ST_RX_PEC`→`ST_RUN` on the code byte.
- Any state→`ST_LOST` on arbitration loss.
- Any state→`ST_RUN` on a start condition. A start condition takes priority over arbitration loss.

Top module: `pec_engine`

## Requirements
- R1: Each `tx_stb` or `rx_stb` folds its byte into the CRC, most significant bit first, with generator x^8+x^2+x+1 (0x07). `crc_val` shows the new value one cycle after the strobe. Starting from zero, byte 0x01 gives 0x07 and byte 0x80 gives 0x89.
- R2: After reset `crc_val` is 0 and every flag output is low. A `start_det` pulse clears `crc_val` to 0 in the next cycle.
- R3: While transmitting with `pec_en` and `dma_en` high, a `dma_eot` pulse does not raise `send_pec` at once. `send_pec` rises the cycle after the next `tx_stb` and falls after the following `tx_stb`. Transmitting the value shown by `crc_val` leaves a remainder of 0.
- R4: While receiving with `pec_en` and `dma_en` high, a `dma_eot_pre` pulse raises `next_is_pec` in the next cycle. It stays high until the cycle after the next `rx_stb`.
- R5: If the byte received while `next_is_pec` is high differs from the current `crc_val`, `pec_err` is high from the next cycle and stays high until `pec_err_clr`. If the byte matches, `pec_err` stays low.
- R6: `pec_irq` is high exactly when `pec_err` and `err_irq_en` are both high.
- R7: After a code byte is received on the DMA path, `dma_req_pec` is high for exactly one cycle, the cycle after the byte. It is never raised on the software path.
- R8: `nack_req` is high together with `next_is_pec` only if the early end-of-transfer arrived with `role_master` and `last_xfer` both high. It stays low for a slave or for an intermediate transfer.
- R9: `arb_lost` raises `crc_corrupt` in the next cycle. From then on, byte strobes leave `crc_val` unchanged and transfer-end triggers are ignored. The next `start_det` clears both `crc_corrupt` and the CRC.
- R10: With `dma_en` low, `sw_pec_req` raises `send_pec` (transmitting) or `next_is_pec` (receiving) in the next cycle, and `dma_eot` has no effect.
- R11: With `pec_en` low, `dma_eot`, `dma_eot_pre` and `sw_pec_req` have no effect, while the CRC keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pec_en | input | 1 | Packet error checking enabled |
| dma_en | input | 1 | Transfer-end triggers come from DMA (1) or software (0) |
| dir_tx | input | 1 | 1 = transmitting, 0 = receiving |
| role_master | input | 1 | 1 = master, 0 = slave |
| last_xfer | input | 1 | Current DMA transfer is the final one |
| err_irq_en | input | 1 | Error interrupt enable |
| start_det | input | 1 | Start condition seen |
| arb_lost | input | 1 | Arbitration lost |
| tx_stb | input | 1 | Transmitted byte completed |
| tx_byte | input | 8 | Transmitted byte |
| rx_stb | input | 1 | Received byte completed |
| rx_byte | input | 8 | Received byte |
| dma_eot | input | 1 | DMA end of transfer (transmit) |
| dma_eot_pre | input | 1 | DMA early end of transfer, one byte before the end (receive) |
| sw_pec_req | input | 1 | Software request to send or check the code |
| pec_err_clr | input | 1 | Clears the sticky error flag |
| crc_val | output | 8 | Running CRC |
| send_pec | output | 1 | Transmit the code byte next |
| next_is_pec | output | 1 | Next received byte is the code |
| nack_req | output | 1 | NACK the next received byte |
| dma_req_pec | output | 1 | DMA request after the code byte |
| crc_corrupt | output | 1 | CRC invalid after arbitration loss |
| pec_err | output | 1 | Sticky code mismatch flag |
| pec_irq | output | 1 | Error interrupt |

## Verification
The hardest situations to reach are a code byte that arrives after an intermediate transfer, and an arbitration loss in the middle of a checked frame. Both need the sequencer to be in a non-idle state while the remainder holds a known value. The bench therefore drives full frames: a start, a table of mixed-direction bytes, a transfer-end trigger, and then a deliberately right or wrong code byte. A reference CRC model tracks the frame, so the exact code byte and the expected flags are known in every cycle. The arbitration case issues the loss after a trigger has been armed, and shows that later bytes and triggers leave the outputs untouched until a start.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int PEC_W = 8;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_TX_ARM = 3'd1,
        ST_TX_PEC = 3'd2,
        ST_RX_PEC = 3'd3,
        ST_LOST   = 3'd4
    } pec_state_t;
endpackage

// File: rtl/pec_crc_acc.sv
module pec_crc_acc #(
    parameter int            W    = pec_pkg::PEC_W,
    parameter logic [W-1:0]  POLY = 'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fold,
    input  logic [W-1:0] din,
    output logic [W-1:0] crc_q,
    output logic [W-1:0] crc_nxt
);
    // bit-serial division, most significant bit first
    always_comb begin
        logic [W-1:0] acc;
        logic         fb;
        acc = crc_q;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ din[i];
            acc = {acc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_nxt = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= '0;
        else if (clr)   crc_q <= '0;
        else if (fold)  crc_q <= crc_nxt;
    end
endmodule

// File: rtl/pec_seq.sv
module pec_seq
    import pec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pec_en,
    input  logic dma_en,
    input  logic dir_tx,
    input  logic role_master,
    input  logic last_xfer,
    input  logic start_det,
    input  logic arb_lost,
    input  logic tx_stb,
    input  logic rx_stb,
    input  logic dma_eot,
    input  logic dma_eot_pre,
    input  logic sw_pec_req,
    output logic fold_en,
    output logic crc_clr,
    output logic chk_stb,
    output logic send_pec,
    output logic next_is_pec,
    output logic nack_req,
    output logic dma_req_pec,
    output logic crc_corrupt
);
    pec_state_t state_q, state_d;
    logic       nack_q, nack_d;
    logic       via_dma_q, via_dma_d;
    logic       dma_req_q;
    logic       tx_go, rx_go;

    assign tx_go = pec_en &&  dir_tx && (dma_en ? dma_eot     : sw_pec_req);
    assign rx_go = pec_en && !dir_tx && (dma_en ? dma_eot_pre : sw_pec_req);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            nack_q    <= 1'b0;
            via_dma_q <= 1'b0;
            dma_req_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            nack_q    <= nack_d;
            via_dma_q <= via_dma_d;
            dma_req_q <= chk_stb && via_dma_q;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        nack_d    = nack_q;
        via_dma_d = via_dma_q;
        chk_stb   = 1'b0;
        if (start_det) begin
            state_d = ST_RUN;
            nack_d  = 1'b0;
        end else if (arb_lost) begin
            state_d = ST_LOST;
            nack_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (tx_go) begin
                        state_d   = dma_en ? ST_TX_ARM : ST_TX_PEC;
                        via_dma_d = dma_en;
                    end else if (rx_go) begin
                        state_d   = ST_RX_PEC;
                        via_dma_d = dma_en;
                        nack_d    = dma_en && role_master && last_xfer;
                    end
                end
                ST_TX_ARM: if (tx_stb) state_d = ST_TX_PEC;
                ST_TX_PEC: if (tx_stb) state_d = ST_RUN;
                ST_RX_PEC: begin
                    if (rx_stb) begin
                        chk_stb = 1'b1;
                        state_d = ST_RUN;
                        nack_d  = 1'b0;
                    end
                end
                ST_LOST:   state_d = ST_LOST;
                default:   state_d = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        crc_clr     = start_det;
        fold_en     = (tx_stb || rx_stb) && (state_q != ST_LOST) && !start_det;
        send_pec    = (state_q == ST_TX_PEC);
        next_is_pec = (state_q == ST_RX_PEC);
        nack_req    = (state_q == ST_RX_PEC) && nack_q;
        crc_corrupt = (state_q == ST_LOST);
        dma_req_pec = dma_req_q;
    end
endmodule

// File: rtl/pec_err_flag.sv
module pec_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic chk_stb,
    input  logic mismatch,
    input  logic clr,
    input  logic irq_en,
    output logic err_q,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    err_q <= 1'b0;
        else if (chk_stb && mismatch)  err_q <= 1'b1;
        else if (clr)                  err_q <= 1'b0;
    end

    assign irq = err_q && irq_en;
endmodule

// File: rtl/pec_engine.sv
module pec_engine #(
    parameter int                       W    = pec_pkg::PEC_W,
    parameter logic [pec_pkg::PEC_W-1:0] POLY = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pec_en,
    input  logic         dma_en,
    input  logic         dir_tx,
    input  logic         role_master,
    input  logic         last_xfer,
    input  logic         err_irq_en,
    input  logic         start_det,
    input  logic         arb_lost,
    input  logic         tx_stb,
    input  logic [W-1:0] tx_byte,
    input  logic         rx_stb,
    input  logic [W-1:0] rx_byte,
    input  logic         dma_eot,
    input  logic         dma_eot_pre,
    input  logic         sw_pec_req,
    input  logic         pec_err_clr,
    output logic [W-1:0] crc_val,
    output logic         send_pec,
    output logic         next_is_pec,
    output logic         nack_req,
    output logic         dma_req_pec,
    output logic         crc_corrupt,
    output logic         pec_err,
    output logic         pec_irq
);
    logic         fold_en, crc_clr, chk_stb;
    logic [W-1:0] crc_nxt, din;

    assign din = tx_stb ? tx_byte : rx_byte;

    pec_crc_acc #(.W(W), .POLY(POLY[W-1:0])) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (crc_clr),
        .fold    (fold_en),
        .din     (din),
        .crc_q   (crc_val),
        .crc_nxt (crc_nxt)
    );

    pec_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pec_en      (pec_en),
        .dma_en      (dma_en),
        .dir_tx      (dir_tx),
        .role_master (role_master),
        .last_xfer   (last_xfer),
        .start_det   (start_det),
        .arb_lost    (arb_lost),
        .tx_stb      (tx_stb),
        .rx_stb      (rx_stb),
        .dma_eot     (dma_eot),
        .dma_eot_pre (dma_eot_pre),
        .sw_pec_req  (sw_pec_req),
        .fold_en     (fold_en),
        .crc_clr     (crc_clr),
        .chk_stb     (chk_stb),
        .send_pec    (send_pec),
        .next_is_pec (next_is_pec),
        .nack_req    (nack_req),
        .dma_req_pec (dma_req_pec),
        .crc_corrupt (crc_corrupt)
    );

    // zero remainder after folding the code byte means pass
    pec_err_flag u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_stb  (chk_stb),
        .mismatch (crc_nxt != '0),
        .clr      (pec_err_clr),
        .irq_en   (err_irq_en),
        .err_q    (pec_err),
        .irq      (pec_irq)
    );
endmodule

// File: rtl/pec_engine_chk.sv
module pec_engine_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_det,
    input logic         arb_lost,
    input logic         rx_stb,
    input logic [W-1:0] rx_byte,
    input logic         pec_err_clr,
    input logic [W-1:0] crc_val,
    input logic         send_pec,
    input logic         next_is_pec,
    input logic         nack_req,
    input logic         dma_req_pec,
    input logic         crc_corrupt,
    input logic         pec_err
);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (crc_val == '0 && !crc_corrupt));

    assert_tx_rx_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_pec && next_is_pec));

    assert_mismatch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (next_is_pec && rx_stb && !start_det && !arb_lost && rx_byte != crc_val) |=> pec_err);

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_err && !pec_err_clr) |=> pec_err);

    assert_dma_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_pec |=> !dma_req_pec);

    assert_dma_after_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req_pec) |-> $past(rx_stb && next_is_pec));

    assert_nack_with_pec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |-> next_is_pec);

    assert_lost_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_corrupt && !start_det) |=> $stable(crc_val));

    assert_lost_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        crc_corrupt |-> !(send_pec || next_is_pec));
endmodule

bind pec_engine pec_engine_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (start_det),
    .arb_lost    (arb_lost),
    .rx_stb      (rx_stb),
    .rx_byte     (rx_byte),
    .pec_err_clr (pec_err_clr),
    .crc_val     (crc_val),
    .send_pec    (send_pec),
    .next_is_pec (next_is_pec),
    .nack_req    (nack_req),
    .dma_req_pec (dma_req_pec),
    .crc_corrupt (crc_corrupt),
    .pec_err     (pec_err)
);

// File: tb/test_pec_engine.sv
module test_pec_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pec_en = 1'b1, dma_en = 1'b1, dir_tx = 1'b1, role_master = 1'b1;
    logic       last_xfer = 1'b1, err_irq_en = 1'b0;
    logic       start_det = 1'b0, arb_lost = 1'b0;
    logic       tx_stb = 1'b0, rx_stb = 1'b0;
    logic [7:0] tx_byte = 8'h00, rx_byte = 8'h00;
    logic       dma_eot = 1'b0, dma_eot_pre = 1'b0, sw_pec_req = 1'b0, pec_err_clr = 1'b0;
    logic [7:0] crc_val;
    logic       send_pec, next_is_pec, nack_req, dma_req_pec, crc_corrupt, pec_err, pec_irq;

    int         n_cmp = 0, n_bad = 0;
    logic [7:0] m_crc = 8'h00;
    bit         done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    pec_engine i_pec_engine (
        .clk(clk), .rst_n(rst_n), .pec_en(pec_en), .dma_en(dma_en), .dir_tx(dir_tx),
        .role_master(role_master), .last_xfer(last_xfer), .err_irq_en(err_irq_en),
        .start_det(start_det), .arb_lost(arb_lost), .tx_stb(tx_stb), .tx_byte(tx_byte),
        .rx_stb(rx_stb), .rx_byte(rx_byte), .dma_eot(dma_eot), .dma_eot_pre(dma_eot_pre),
        .sw_pec_req(sw_pec_req), .pec_err_clr(pec_err_clr), .crc_val(crc_val),
        .send_pec(send_pec), .next_is_pec(next_is_pec), .nack_req(nack_req),
        .dma_req_pec(dma_req_pec), .crc_corrupt(crc_corrupt), .pec_err(pec_err),
        .pec_irq(pec_irq)
    );

    // stimulus table: {1 = transmitted / 0 = received, byte}
    localparam logic [8:0] VEC [8] = '{
        {1'b1, 8'h5A}, {1'b0, 8'hC3}, {1'b1, 8'h00}, {1'b0, 8'hFF},
        {1'b1, 8'h80}, {1'b0, 8'h01}, {1'b1, 8'h7E}, {1'b0, 8'hA5}
    };

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c ^ b;
        repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_tx(input logic [7:0] b);
        tx_stb = 1'b1; tx_byte = b;
        @(negedge clk);
        tx_stb = 1'b0;
        m_crc = ref_crc(m_crc, b);
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_stb = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_stb = 1'b0;
        m_crc = ref_crc(m_crc, b);
    endtask

    task automatic do_start();
        start_det = 1'b1;
        @(negedge clk);
        start_det = 1'b0;
        m_crc = 8'h00;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] hold;
        repeat (3) @(negedge clk);
        // R2 reset state
        check(crc_val == 8'h00 && !send_pec && !next_is_pec && !nack_req && !dma_req_pec
              && !crc_corrupt && !pec_err && !pec_irq, "R2 reset", {24'h0, crc_val}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 hand values
        do_start();
        send_tx(8'h01);
        check(crc_val == 8'h07, "R1 byte 01", crc_val, 8'h07);
        do_start();
        check(crc_val == 8'h00, "R2 start clears", crc_val, 0);
        send_rx(8'h80);
        check(crc_val == 8'h89, "R1 byte 80", crc_val, 8'h89);

        // R1 table walk
        do_start();
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][8]) send_tx(VEC[i][7:0]);
            else           send_rx(VEC[i][7:0]);
            check(crc_val == m_crc, "R1 table", crc_val, m_crc);
        end

        // R3 DMA transmit
        dir_tx = 1'b1; dma_en = 1'b1;
        do_start();
        send_tx(8'h10); send_tx(8'h22);
        dma_eot = 1'b1; @(negedge clk); dma_eot = 1'b0;
        check(!send_pec, "R3 not before last byte", send_pec, 0);
        send_tx(8'h33);
        check(send_pec, "R3 request after last byte", send_pec, 1);
        send_tx(m_crc);
        check(!send_pec && crc_val == 8'h00, "R3 code sent", {crc_val, 7'h0, send_pec}, 0);

        // R4 R7 R8 master final receive, good code
        dir_tx = 1'b0; role_master = 1'b1; last_xfer = 1'b1;
        do_start();
        send_rx(8'h41); send_rx(8'h9C);
        dma_eot_pre = 1'b1; @(negedge clk); dma_eot_pre = 1'b0;
        check(next_is_pec, "R4 next is code", next_is_pec, 1);
        check(nack_req, "R8 master final nack", nack_req, 1);
        check(!dma_req_pec, "R7 no request early", dma_req_pec, 0);
        send_rx(m_crc);
        check(dma_req_pec && !next_is_pec && !nack_req, "R7 request after code",
              {dma_req_pec, next_is_pec, nack_req}, 3'b100);
        check(!pec_err, "R5 good code", pec_err, 0);
        @(negedge clk);
        check(!dma_req_pec, "R7 single pulse", dma_req_pec, 0);

        // R8 intermediate master transfer
        last_xfer = 1'b0;
        send_rx(8'h05);
        dma_eot_pre = 1'b1; @(negedge clk); dma_eot_pre = 1'b0;
        check(next_is_pec && !nack_req, "R8 intermediate no nack", nack_req, 0);
        send_rx(m_crc);

        // R5 R6 R8 slave, wrong code
        role_master = 1'b0; last_xfer = 1'b1; err_irq_en = 1'b0;
        do_start();
        send_rx(8'h77);
        dma_eot_pre = 1'b1; @(negedge clk); dma_eot_pre = 1'b0;
        check(!nack_req, "R8 slave no nack", nack_req, 0);
        send_rx(m_crc ^ 8'h01);
        check(pec_err && !pec_irq, "R5 mismatch flag, R6 masked", {pec_err, pec_irq}, 2'b10);
        repeat (3) @(negedge clk);
        check(pec_err, "R5 sticky", pec_err, 1);
        err_irq_en = 1'b1; #1;
        check(pec_irq, "R6 irq enabled", pec_irq, 1);
        pec_err_clr = 1'b1; @(negedge clk); pec_err_clr = 1'b0;
        check(!pec_err && !pec_irq, "R5 cleared", {pec_err, pec_irq}, 0);

        // R9 arbitration loss
        dir_tx = 1'b1; dma_en = 1'b1;
        do_start();
        send_tx(8'hE1);
        dma_eot = 1'b1; @(negedge clk); dma_eot = 1'b0;
        arb_lost = 1'b1; @(negedge clk); arb_lost = 1'b0;
        check(crc_corrupt, "R9 corrupt set", crc_corrupt, 1);
        hold = crc_val;
        tx_stb = 1'b1; tx_byte = 8'h3C; @(negedge clk); tx_stb = 1'b0;
        check(crc_val == hold && !send_pec, "R9 byte ignored", crc_val, hold);
        dma_eot = 1'b1; @(negedge clk); dma_eot = 1'b0;
        tx_stb = 1'b1; @(negedge clk); tx_stb = 1'b0;
        check(!send_pec && crc_val == hold, "R9 trigger ignored", send_pec, 0);
        do_start();
        check(!crc_corrupt && crc_val == 8'h00, "R9 start recovers", {crc_val, 7'h0, crc_corrupt}, 0);

        // R10 software path
        dma_en = 1'b0; dir_tx = 1'b1;
        send_tx(8'h12);
        dma_eot = 1'b1; @(negedge clk); dma_eot = 1'b0;
        check(!send_pec, "R10 eot ignored", send_pec, 0);
        sw_pec_req = 1'b1; @(negedge clk); sw_pec_req = 1'b0;
        check(send_pec, "R10 sw send", send_pec, 1);
        send_tx(m_crc);
        check(!send_pec && crc_val == 8'h00, "R10 sw code sent", send_pec, 0);
        dir_tx = 1'b0; role_master = 1'b1;
        send_rx(8'h6B);
        sw_pec_req = 1'b1; @(negedge clk); sw_pec_req = 1'b0;
        check(next_is_pec && !nack_req, "R10 sw receive", {next_is_pec, nack_req}, 2'b10);
        send_rx(m_crc);
        check(!dma_req_pec && !pec_err, "R7 no request on sw path", dma_req_pec, 0);

        // R11 checking disabled
        pec_en = 1'b0; dma_en = 1'b1;
        dma_eot_pre = 1'b1; @(negedge clk); dma_eot_pre = 1'b0;
        check(!next_is_pec, "R11 eot_pre ignored", next_is_pec, 0);
        send_rx(8'h99);
        check(crc_val == m_crc && !next_is_pec, "R11 crc runs", crc_val, m_crc);
        dir_tx = 1'b1;
        dma_eot = 1'b1; @(negedge clk); dma_eot = 1'b0;
        send_tx(8'h01);
        check(!send_pec, "R11 eot ignored", send_pec, 0);

        finish_run();
    end
endmodule